// File: doc/BRIEF.md
# Character LCD Row Scanner with Serial Segment Output

This block scans the common (row) lines of a character dot-matrix LCD and streams each row's column dots, one bit at a time, to a chain of external segment shift drivers. An upstream pixel source receives a one-cycle request at the start of every row. It then supplies that row's dots over a valid/ready handshake. The scanner forwards each dot on a serial data line with a companion shift clock. Once the whole row has been shifted, it pulses a load strobe. On that same clock edge it moves the one-hot common select to the row just delivered.

A two-bit mode input chooses one of four duties. The duty fixes how many commons are scanned per frame: 16, 24, 32 or 48. It also fixes how many dots make up a row: five per character, with either a wide or a narrow line of characters. A frame-alternation output flips once per completed frame so the panel sees AC drive. Character lookup, font storage, the processor bus and analog bias are outside the block.

Top module: `lcd_scan_drv`

## Requirements
- R1: The mode code selects the duty and the row length. Code 0 gives 16 commons with CHARS_WIDE*5 dots per row. Code 1 gives 24 commons with CHARS_WIDE*5 dots. Code 2 gives 32 commons with CHARS_NARROW*5 dots. Code 3 gives 48 commons with CHARS_NARROW*5 dots.
- R2: The mode input is captured only when the request for row 0 of a frame is issued. A change in mid-frame takes effect from the next frame.
- R3: Dots leave on seg_data in the order they were accepted, one per seg_clk high pulse. seg_data changes only while seg_clk is low and holds its value during every high pulse.
- R4: At most one com bit is high. com[r] becomes the only active common when row r is loaded, so only com[0] to com[N-1] are ever used for duty N. All commons are low from reset until the first load.
- R5: seg_load is a one-cycle pulse, issued the cycle after the last dot's clock pulse of a row. seg_clk is low while seg_load is high, and com changes only on the edge that raises seg_load.
- R6: frame_alt toggles only on the edge that loads row N-1, so it toggles once per frame.
- R7: row_req is a one-cycle pulse, issued exactly once before each row's dots. pix_ready is low while row_req or seg_load is high.
- R8: While pix_ready is high and pix_valid is low, seg_clk stays low and seg_data holds its value.
- R9: Synchronous reset clears com, frame_alt, seg_load, seg_clk and seg_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Duty selection code (see R1) |
| pix_valid | input | 1 | Upstream dot is present |
| pix_bit | input | 1 | Upstream dot value |
| pix_ready | output | 1 | Scanner is waiting for a dot |
| row_req | output | 1 | Pulse asking for the next row |
| seg_data | output | 1 | Serial dot data to segment drivers |
| seg_clk | output | 1 | Shift clock to segment drivers |
| seg_load | output | 1 | Row latch strobe to segment drivers |
| frame_alt | output | 1 | Frame alternation (AC polarity) |
| com | output | 48 | One-hot common select |

## Verification
The bound checker enforces the following on every cycle:
- the one-hot commons;
- data holding during the shift clock's high phase;
- the shape of the load pulse and the absence of a shift clock during it;
- the rule that commons and frame_alt move only on a load;
- the idle shift clock during an input stall.

Some behaviour cannot be seen in a single cycle, so only the bench's scenarios show it. This covers the bit order and content of each row, the row length and common count for each duty, the frame at which a mid-frame mode change takes effect, and the row at which frame_alt flips. The bench sweeps all four modes through several frames with irregular and long input stalls.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int NUM_COM = 48;

  typedef enum logic [1:0] {
    DUTY16 = 2'd0,
    DUTY24 = 2'd1,
    DUTY32 = 2'd2,
    DUTY48 = 2'd3
  } duty_e;

  typedef enum logic [2:0] {
    ST_REQ  = 3'd0,
    ST_LO   = 3'd1,
    ST_RISE = 3'd2,
    ST_FALL = 3'd3,
    ST_LOAD = 3'd4
  } shift_st_e;
endpackage

// File: rtl/lcd_mode_dec.sv
module lcd_mode_dec
  import lcd_scan_pkg::*;
#(
  parameter int CHARS_WIDE   = 80,
  parameter int CHARS_NARROW = 40,
  parameter int CHAR_W       = 5,
  parameter int ROW_W        = 6,
  parameter int BIT_W        = 9
) (
  input  duty_e             duty_i,
  output logic [ROW_W-1:0]  rows_o,
  output logic [BIT_W-1:0]  bits_o
);
  localparam int WIDE_BITS   = CHARS_WIDE * CHAR_W;
  localparam int NARROW_BITS = CHARS_NARROW * CHAR_W;

  always_comb begin
    case (duty_i)
      DUTY16:  begin rows_o = ROW_W'(16); bits_o = BIT_W'(WIDE_BITS);   end
      DUTY24:  begin rows_o = ROW_W'(24); bits_o = BIT_W'(WIDE_BITS);   end
      DUTY32:  begin rows_o = ROW_W'(32); bits_o = BIT_W'(NARROW_BITS); end
      default: begin rows_o = ROW_W'(48); bits_o = BIT_W'(NARROW_BITS); end
    endcase
  end
endmodule

// File: rtl/lcd_shift_seq.sv
module lcd_shift_seq
  import lcd_scan_pkg::*;
#(
  parameter int BIT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BIT_W-1:0] bits_i,
  input  logic             pix_valid_i,
  input  logic             pix_bit_i,
  output logic             pix_ready_o,
  output logic             row_req_o,
  output logic             sd_o,
  output logic             scl_o,
  output logic             ld_o,
  output logic             load_go_o
);
  shift_st_e        state;
  logic [BIT_W-1:0] cnt;
  logic             last_bit;

  assign last_bit    = (cnt == bits_i - BIT_W'(1));
  assign load_go_o   = (state == ST_FALL) && last_bit;
  assign pix_ready_o = (state == ST_LO);
  assign row_req_o   = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD;
      cnt   <= '0;
      sd_o  <= 1'b0;
      scl_o <= 1'b0;
      ld_o  <= 1'b0;
    end else begin
      case (state)
        ST_REQ: begin
          cnt   <= '0;
          state <= ST_LO;
        end
        ST_LO: begin
          if (pix_valid_i) begin
            sd_o  <= pix_bit_i;
            state <= ST_RISE;
          end
        end
        ST_RISE: begin
          scl_o <= 1'b1;
          state <= ST_FALL;
        end
        ST_FALL: begin
          scl_o <= 1'b0;
          if (last_bit) begin
            ld_o  <= 1'b1;
            state <= ST_LOAD;
          end else begin
            cnt   <= cnt + BIT_W'(1);
            state <= ST_LO;
          end
        end
        default: begin
          ld_o  <= 1'b0;
          state <= ST_REQ;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv #(
  parameter int NUM   = 48,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [NUM-1:0]   com_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_com
    always_ff @(posedge clk) begin
      if (rst)         com_o[i] <= 1'b0;
      else if (load_i) com_o[i] <= (row_i == ROW_W'(i));
    end
  end
endmodule

// File: rtl/lcd_scan_drv.sv
module lcd_scan_drv
  import lcd_scan_pkg::*;
#(
  parameter int CHARS_WIDE   = 80,
  parameter int CHARS_NARROW = 40,
  parameter int CHAR_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              pix_valid,
  input  logic              pix_bit,
  output logic              pix_ready,
  output logic              row_req,
  output logic              seg_data,
  output logic              seg_clk,
  output logic              seg_load,
  output logic              frame_alt,
  output logic [NUM_COM-1:0] com
);
  localparam int MAX_BITS = (CHARS_WIDE > CHARS_NARROW ? CHARS_WIDE : CHARS_NARROW) * CHAR_W;
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam int ROW_W    = $clog2(NUM_COM + 1);

  duty_e            mode_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] rows;
  logic [BIT_W-1:0] bits;
  logic             load_go;

  lcd_mode_dec #(
    .CHARS_WIDE  (CHARS_WIDE),
    .CHARS_NARROW(CHARS_NARROW),
    .CHAR_W      (CHAR_W),
    .ROW_W       (ROW_W),
    .BIT_W       (BIT_W)
  ) mode_dec_i (
    .duty_i(mode_q),
    .rows_o(rows),
    .bits_o(bits)
  );

  lcd_shift_seq #(.BIT_W(BIT_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .bits_i     (bits),
    .pix_valid_i(pix_valid),
    .pix_bit_i  (pix_bit),
    .pix_ready_o(pix_ready),
    .row_req_o  (row_req),
    .sd_o       (seg_data),
    .scl_o      (seg_clk),
    .ld_o       (seg_load),
    .load_go_o  (load_go)
  );

  lcd_com_drv #(.NUM(NUM_COM), .ROW_W(ROW_W)) com_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_go),
    .row_i (row_q),
    .com_o (com)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= DUTY16;
      row_q     <= '0;
      frame_alt <= 1'b0;
    end else begin
      if (row_req && row_q == '0) mode_q <= duty_e'(mode);
      if (load_go) begin
        if (row_q == rows - ROW_W'(1)) begin
          row_q     <= '0;
          frame_alt <= ~frame_alt;
        end else begin
          row_q <= row_q + ROW_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lcd_scan_drv_chk.sv
module lcd_scan_drv_chk (
  input logic        clk,
  input logic        rst,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic        row_req,
  input logic        seg_data,
  input logic        seg_clk,
  input logic        seg_load,
  input logic        frame_alt,
  input logic [47:0] com
);
  a_r4_com_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com));
  a_r4_com_moves_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(com) |-> seg_load);
  a_r5_no_clk_in_load: assert property (@(posedge clk) disable iff (rst)
    seg_load |-> !seg_clk);
  a_r5_load_one_cycle: assert property (@(posedge clk) disable iff (rst)
    seg_load |=> !seg_load);
  a_r3_data_hold_high: assert property (@(posedge clk) disable iff (rst)
    seg_clk |-> $stable(seg_data));
  a_r6_alt_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_alt) |-> seg_load);
  a_r7_req_not_ready: assert property (@(posedge clk) disable iff (rst)
    (row_req || seg_load) |-> !pix_ready);
  a_r8_stall_idle: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && !pix_valid) |=> (!seg_clk && $stable(seg_data)));
endmodule

bind lcd_scan_drv lcd_scan_drv_chk chk_i (.*);

// File: tb/lcd_scan_drv_tb.sv
module lcd_scan_drv_tb_top;
  localparam int CW = 4;
  localparam int CN = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        pix_valid = 1'b0;
  logic        pix_bit = 1'b0;
  logic        pix_ready, row_req, seg_data, seg_clk, seg_load, frame_alt;
  logic [47:0] com;

  lcd_scan_drv #(.CHARS_WIDE(CW), .CHARS_NARROW(CN), .CHAR_W(5)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .pix_valid(pix_valid), .pix_bit(pix_bit),
    .pix_ready(pix_ready), .row_req(row_req), .seg_data(seg_data), .seg_clk(seg_clk),
    .seg_load(seg_load), .frame_alt(frame_alt), .com(com)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  int frames = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pat(input int n, input int k);
    return ((n * 5 + k * 3 + k / 4) % 7) < 3;
  endfunction

  function automatic int rows_of(input int m);
    return (m == 0) ? 16 : (m == 1) ? 24 : (m == 2) ? 32 : 48;
  endfunction

  function automatic int bits_of(input int m);
    return (m < 2) ? CW * 5 : CN * 5;
  endfunction

  int src_n, src_k, hold, mon_idx, n_ld, rowpos, req_seen, mode_exp;
  bit fr_exp, prev_scl, prev_ready, prev_valid, prev_sd;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      src_n = -1; src_k = 0; hold = 0; mon_idx = 0; n_ld = 0; rowpos = 0;
      req_seen = 0; mode_exp = 0; fr_exp = 0;
      prev_scl = 0; prev_ready = 0; prev_valid = 0; prev_sd = 0;
      pix_valid = 0;
    end else if (!done) begin
      if (prev_ready && prev_valid) src_k++;
      if (prev_ready && !prev_valid) begin
        chk(!seg_clk && seg_data == prev_sd, "R8 stall", {seg_clk, seg_data}, {1'b0, prev_sd});
      end
      if (row_req) begin
        req_seen++; src_n++; src_k = 0; hold = 0;
        if (rowpos == 0) mode_exp = int'(mode);
        chk(!pix_ready, "R7 ready during request", pix_ready, 0);
      end
      if (seg_clk && !prev_scl) begin
        chk(seg_data == pat(n_ld, mon_idx), "R3 serial bit", seg_data, pat(n_ld, mon_idx));
        mon_idx++;
      end
      if (seg_load) begin
        chk(mon_idx == bits_of(mode_exp), "R1 dots per row", mon_idx, bits_of(mode_exp));
        chk(req_seen == 1, "R7 one request per row", req_seen, 1);
        chk(!seg_clk && !pix_ready, "R5 quiet during load", {seg_clk, pix_ready}, 0);
        if (rowpos == rows_of(mode_exp) - 1) fr_exp = ~fr_exp;
        chk(com == (48'd1 << rowpos), "R4 common select", com, 48'd1 << rowpos);
        chk(frame_alt == fr_exp, "R6 frame alternation", frame_alt, fr_exp);
        if (rowpos == rows_of(mode_exp) - 1) begin
          rowpos = 0; frames++;
        end else begin
          rowpos++;
        end
        n_ld++; mon_idx = 0; req_seen = 0;
      end
      if (src_n % 9 == 4 && src_k == 2 && hold < 15) begin
        hold++;
        pix_valid = 1'b0;
      end else begin
        pix_valid = ((cyc + src_k) % 4) != 3;
      end
      pix_bit    = pat(src_n, src_k);
      prev_scl   = seg_clk;
      prev_ready = pix_ready;
      prev_valid = pix_valid;
      prev_sd    = seg_data;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    chk(com == 48'd0, "R9 com in reset", com, 0);
    chk({frame_alt, seg_load, seg_clk, seg_data} == 4'd0, "R9 outputs in reset",
        {frame_alt, seg_load, seg_clk, seg_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(com == 48'd0, "R4 no common before first load", com, 0);
    for (int m = 0; m < 4; m++) begin
      int target;
      // R2: mode changes land mid-frame; the model applies them from the next frame
      repeat (37 * (m + 1)) @(negedge clk);
      mode = 2'(m);
      target = frames + 3;
      while (frames < target) @(negedge clk);
    end
    mode = 2'd1;
    repeat (500) @(negedge clk);
    mode = 2'd3;
    begin
      int target2;
      target2 = frames + 2;
      while (frames < target2) @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule